// File: doc/BRIEF.md
# Launch/Capture Delay-Test Scan Sequencer

This block sequences a mux-scan chain through at-speed transition and path-delay patterns. For each pattern it shifts the first test vector into the chain with slow clock pulses and then makes the second vector in one of two ways, chosen by a mode input. In shift-launch mode the second vector comes from one more scan shift. In capture-launch mode it comes from one functional clock through the logic under test. After that it fires a single capture pulse in normal mode, one rated period after the launch.

The block drives the chain's scan-enable and a per-cycle clock enable. It also drives a fast-period flag that a clock generator uses to pick the rated period for the launch-to-capture interval. The shift of the next pattern unloads the previous response at the same time. After the last pattern, a final unload pass runs and a one-cycle done pulse follows. Chain length, pattern count and mode are taken when a session starts and hold for the whole session.

Top module: `delay_test_seq`

States: IDLE, SHIFT, LAUNCH, CAPTURE, UNLOAD, FINISH. Transitions: IDLE to SHIFT on an accepted start. SHIFT to LAUNCH after the last shift cycle. LAUNCH to CAPTURE always. CAPTURE to SHIFT if more patterns remain, else to UNLOAD. UNLOAD to FINISH after the last unload cycle. FINISH to IDLE always.

## Requirements
- R1: After reset the block is idle. busy, done, fast, scan-enable and clock-enable are all 0, and the shift count is 0.
- R2: An accepted start is a start pulse in IDLE with nonzero chain length and nonzero pattern count. From the next cycle, each pattern begins with chain-length shift cycles. In each one scan-enable=1, clock-enable=1 and fast=0, and the shift count runs 0 up to length-1.
- R3: With mode input 1 (shift-launch), the cycle after the last shift is a launch cycle with scan-enable=1, clock-enable=1 and fast=0.
- R4: With mode input 0 (capture-launch), the launch cycle has scan-enable=0, clock-enable=1 and fast=0.
- R5: The cycle after launch is the capture cycle, with scan-enable=0, clock-enable=1 and fast=1. fast is 1 in no other cycle. In shift-launch mode scan-enable therefore falls between the launch and capture edges.
- R6: After a capture that is not the last, the next pattern's shift cycles begin at once and the pattern index goes up by one. The pattern index is 0 for the first pattern.
- R7: After the last capture come chain-length unload cycles (scan-enable=1, clock-enable=1). Then one cycle with done=1 and scan-enable and clock-enable both 0. The block is idle in the cycle after that.
- R8: busy is 1 from the first shift cycle through the done cycle, and 0 otherwise.
- R9: A start pulse while busy is ignored. Changes to mode, length or count while busy have no effect on the running schedule.
- R10: A start pulse with chain length 0 or pattern count 0 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one tick per test clock slot |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Session start request |
| los_mode_i | input | 1 | 1 = launch by extra shift, 0 = launch by functional capture |
| chain_len_i | input | LEN_W | Scan chain length in cells |
| pat_num_i | input | PAT_W | Number of patterns in the session |
| scan_en_o | output | 1 | Scan-enable to the chain muxes |
| clk_en_o | output | 1 | Test clock pulse enable for this slot |
| fast_o | output | 1 | Rated-period request for this slot |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse after the final unload |
| shift_cnt_o | output | LEN_W | Shift position within a load/unload pass |
| pat_idx_o | output | PAT_W | Index of the current pattern |

## Verification
The hardest situations to reach are the ones at the boundaries. One is a start that arrives mid-session together with changed mode and length. The others are the degenerate one-cell chain, where launch and capture directly follow a single shift, and a start with a zero parameter. The bench drives each of these on purpose. It injects a conflicting start partway through a multi-pattern run and checks that the schedule stays the same cycle by cycle. It runs single-cell sessions in both modes. It pulses start with zero length or zero count and checks that the block stays idle.

// File: rtl/delay_test_pkg.sv
package delay_test_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SHIFT   = 3'd1,
        ST_LAUNCH  = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_UNLOAD  = 3'd4,
        ST_FINISH  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/dts_counter.sv
module dts_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    assign last = (cnt == limit - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= last ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/dts_out_decode.sv
module dts_out_decode
    import delay_test_pkg::*;
(
    input  seq_state_t state,
    input  logic       los,
    output logic       scan_en,
    output logic       clk_en,
    output logic       fast,
    output logic       busy,
    output logic       done
);
    always_comb begin
        scan_en = 1'b0;
        clk_en  = 1'b0;
        fast    = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_SHIFT: begin
                scan_en = 1'b1;
                clk_en  = 1'b1;
            end
            ST_LAUNCH: begin
                scan_en = los;
                clk_en  = 1'b1;
            end
            ST_CAPTURE: begin
                clk_en = 1'b1;
                fast   = 1'b1;
            end
            ST_UNLOAD: begin
                scan_en = 1'b1;
                clk_en  = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/delay_test_seq.sv
module delay_test_seq
    import delay_test_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int PAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             los_mode_i,
    input  logic [LEN_W-1:0] chain_len_i,
    input  logic [PAT_W-1:0] pat_num_i,
    output logic             scan_en_o,
    output logic             clk_en_o,
    output logic             fast_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [LEN_W-1:0] shift_cnt_o,
    output logic [PAT_W-1:0] pat_idx_o
);
    seq_state_t       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [PAT_W-1:0] npat_q;
    logic             los_q;
    logic             accept;
    logic             shift_last, pat_last;
    logic             shift_en, pat_en;

    assign accept   = (state_q == ST_IDLE) && start_i &&
                      (chain_len_i != '0) && (pat_num_i != '0);
    assign shift_en = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
    assign pat_en   = (state_q == ST_CAPTURE) && !pat_last;

    // State register and session parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            npat_q  <= '0;
            los_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                len_q  <= chain_len_i;
                npat_q <= pat_num_i;
                los_q  <= los_mode_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_SHIFT;
            ST_SHIFT:   if (shift_last) state_d = ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = pat_last ? ST_UNLOAD : ST_SHIFT;
            ST_UNLOAD:  if (shift_last) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    dts_counter #(.W(LEN_W)) u_shift_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (shift_en),
        .limit (len_q),
        .cnt   (shift_cnt_o),
        .last  (shift_last)
    );

    dts_counter #(.W(PAT_W)) u_pat_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (pat_en),
        .limit (npat_q),
        .cnt   (pat_idx_o),
        .last  (pat_last)
    );

    dts_out_decode u_dec (
        .state   (state_q),
        .los     (los_q),
        .scan_en (scan_en_o),
        .clk_en  (clk_en_o),
        .fast    (fast_o),
        .busy    (busy_o),
        .done    (done_o)
    );
endmodule

// File: rtl/delay_test_seq_chk.sv
module delay_test_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_en_o,
    input logic             clk_en_o,
    input logic             fast_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [LEN_W-1:0] shift_cnt_o,
    input logic [LEN_W-1:0] len_q,
    input logic             los_q
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scan_en_o && !clk_en_o && !fast_o && !done_o));

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (shift_cnt_o < len_q));

    p_los_launch_in_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_o && los_q) |-> ($past(scan_en_o) && $past(clk_en_o)));

    p_loc_launch_functional_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_o && !los_q) |-> (!$past(scan_en_o) && $past(clk_en_o)));

    p_capture_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fast_o |-> (!scan_en_o && clk_en_o));

    p_single_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fast_o |=> !fast_o);

    p_done_after_unload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(scan_en_o) && !clk_en_o));

    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

bind delay_test_seq delay_test_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en_o   (scan_en_o),
    .clk_en_o    (clk_en_o),
    .fast_o      (fast_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .shift_cnt_o (shift_cnt_o),
    .len_q       (len_q),
    .los_q       (los_q)
);

// File: tb/delay_test_seq_bench.sv
`timescale 1ns/1ps
module delay_test_seq_bench;
    localparam int LW = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          los_mode_i = 1'b0;
    logic [LW-1:0] chain_len_i = '0;
    logic [PW-1:0] pat_num_i = '0;
    logic          scan_en_o, clk_en_o, fast_o, busy_o, done_o;
    logic [LW-1:0] shift_cnt_o;
    logic [PW-1:0] pat_idx_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    delay_test_seq #(.LEN_W(LW), .PAT_W(PW)) u_delay_test_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .los_mode_i(los_mode_i),
        .chain_len_i(chain_len_i), .pat_num_i(pat_num_i),
        .scan_en_o(scan_en_o), .clk_en_o(clk_en_o), .fast_o(fast_o),
        .busy_o(busy_o), .done_o(done_o), .shift_cnt_o(shift_cnt_o),
        .pat_idx_o(pat_idx_o)
    );

    // packed observation: se, ce, fast, busy, done, shift count, pattern index
    function automatic logic [4+LW+PW:0] obs();
        return {scan_en_o, clk_en_o, fast_o, busy_o, done_o, shift_cnt_o, pat_idx_o};
    endfunction

    task automatic check(input string tag, input logic [4+LW+PW:0] exp);
        checks++;
        if (obs() !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, obs(), exp, $time);
        end
    endtask

    task automatic test_reset();
        // R1: idle outputs after reset
        check("R1", {5'b00000, {LW{1'b0}}, {PW{1'b0}}});
    endtask

    // One session, compared cycle by cycle against the schedule of R2..R8.
    // poke=1 injects a conflicting start with other mode/length midway (R9).
    task automatic run_session(input bit los, input int len, input int npat, input bit poke);
        int total;
        los_mode_i  = los;
        chain_len_i = LW'(len);
        pat_num_i   = PW'(npat);
        start_i     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        total = npat * (len + 2) + len + 1;
        for (int t = 0; t < total; t++) begin
            int p, r, u;
            string tag;
            logic [4:0] ctl;
            logic [LW-1:0] ec;
            logic [PW-1:0] ep;
            p = t / (len + 2);
            r = t % (len + 2);
            ec = '0;
            if (p < npat) begin
                ep = PW'(p);
                if (r < len) begin
                    ctl = 5'b11010; ec = LW'(r);
                    tag = (p > 0) ? "R6" : "R2";
                end else if (r == len) begin
                    ctl = {los, 4'b1010};
                    tag = los ? "R3" : "R4";
                end else begin
                    ctl = 5'b01110; tag = "R5";
                end
            end else begin
                u = t - npat * (len + 2);
                ep = PW'(npat - 1);
                if (u < len) begin
                    ctl = 5'b11010; ec = LW'(u); tag = "R7";
                end else begin
                    ctl = 5'b00011; tag = "R7";
                end
            end
            if (poke) tag = "R9";
            check(tag, {ctl, ec, ep});
            if (poke && t == 2) begin
                start_i = 1'b1; los_mode_i = ~los; chain_len_i = LW'(len + 3);
            end
            if (poke && t == 3) begin
                start_i = 1'b0; pat_num_i = PW'(npat + 2);
            end
            @(negedge clk);
        end
        // R8: idle again after the done cycle
        check("R8", {5'b00000, {LW{1'b0}}, PW'(npat - 1)});
    endtask

    // R10: zero length or zero pattern count leaves the block idle
    task automatic run_zero(input int len, input int npat);
        chain_len_i = LW'(len);
        pat_num_i   = PW'(npat);
        start_i     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            checks++;
            if (busy_o !== 1'b0 || clk_en_o !== 1'b0) begin
                errors++;
                $display("FAIL R10 actual busy=%b ce=%b expected busy=0 ce=0", busy_o, clk_en_o);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_session(1'b1, 5, 3, 1'b0);
        run_session(1'b0, 4, 2, 1'b0);
        run_session(1'b1, 1, 1, 1'b0);
        run_session(1'b0, 1, 2, 1'b0);
        run_session(1'b1, 6, 2, 1'b1);
        run_session(1'b0, 3, 3, 1'b1);
        run_zero(0, 2);
        run_zero(4, 0);
        run_session(1'b1, 2, 1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule